// File: doc/BRIEF.md
# Power-Up Strap Latch Controller

This block manages a shared pad that has two jobs. It first acts as a configuration input and later carries a clock. Once the supply is reported good, a timed window opens. During the window the pad's output driver stays off, so an external pull resistor alone sets the pad level. When the window closes, the block captures the synchronized pad level as a select bit and enables the pad driver. From then on the pad carries the reference clock.

The captured bit chooses which of two companion clock sources reaches a second output. A captured 0 selects the 48 MHz source and a captured 1 selects the 24 MHz source. That output stays low until capture is complete. The bit stays frozen for as long as the supply stays good. Losing supply-good, or the power-on reset, returns the block to its waiting state, and the next power-up runs a fresh window from zero.

Top module: `strap_clk_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the block ends that edge with `pin_oe`=0, `done`=0, `sel_24m`=0 and `comp_out`=0.
- R2: `pin_oe` goes high on the WINDOW_CYCLES-th consecutive rising edge at which `pwr_good` is sampled high, and is 0 on every edge before that.
- R3: `done` rises on the same edge as `pin_oe`, and the two are equal at all times.
- R4: On the edge that closes the window, `sel_24m` takes the value `pin_in` had two edges earlier (two-flop synchronizer). Changes to `pin_in` later than that are not captured.
- R5: After `done` is high, changes on `pin_in` leave `sel_24m` unchanged while `pwr_good` stays high.
- R6: `comp_out` is 0 whenever `done` is 0, whatever the source inputs are.
- R7: After `done`, `comp_out` follows `src_48` when `sel_24m`=0 and follows `src_24` when `sel_24m`=1.
- R8: An edge with `pwr_good` low clears `pin_oe`, `done` and `sel_24m`. When `pwr_good` returns, a complete window of WINDOW_CYCLES edges must pass before `pin_oe` rises again, even if an earlier window was cut short.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwr_good | input | 1 | Supply has reached its threshold |
| pin_in | input | 1 | Level read back from the shared pad |
| src_48 | input | 1 | 48 MHz companion source |
| src_24 | input | 1 | 24 MHz companion source |
| pin_oe | output | 1 | Pad driver enable; the pad carries the reference clock when high |
| done | output | 1 | Strap captured and pad driving |
| sel_24m | output | 1 | Captured strap: 1 selects 24 MHz, 0 selects 48 MHz |
| comp_out | output | 1 | Gated companion clock |

## Verification
If the window counter is off by even one count, `pin_oe` and `done` rise one edge early or late. The bench sees this at the first sample after the expected edge. A synchronizer that is too short or too long shows up as the wrong captured value when the pad level changes at one of the last two edges of the window. This is seen as soon as the window closes. A capture register that is not frozen, or a restart that does not clear the counter, is seen on `sel_24m` within a few cycles of toggling the pad, or on `pin_oe` at the end of the restarted window.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_LIVE   = 2'd2
  } strap_state_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  output logic win_end,
  output logic live
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  strap_state_t     state;
  logic [CNT_W-1:0] cnt;

  // The window closes on the WINDOW_CYCLES-th edge with supply good.
  assign win_end = pwr_good && (state == ST_WINDOW) && (cnt == LAST);
  assign live    = (state == ST_LIVE);

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_WINDOW;
          cnt   <= CNT_W'(1);
        end
        ST_WINDOW: begin
          if (cnt == LAST) state <= ST_LIVE;
          else             cnt   <= cnt + CNT_W'(1);
        end
        default: state <= ST_LIVE;
      endcase
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic capture,
  input  logic strap_lvl,
  output logic sel_q,
  output logic oe_q
);
  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      sel_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (capture) begin
      sel_q <= strap_lvl;
      oe_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_clk_ctrl.sv
module strap_clk_ctrl #(
  parameter int WINDOW_CYCLES = 28636,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic pin_in,
  input  logic src_48,
  input  logic src_24,
  output logic pin_oe,
  output logic done,
  output logic sel_24m,
  output logic comp_out
);
  logic pin_sync;
  logic win_end;
  logic live;

  strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .win_end  (win_end),
    .live     (live)
  );

  strap_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .capture   (win_end),
    .strap_lvl (pin_sync),
    .sel_q     (sel_24m),
    .oe_q      (pin_oe)
  );

  assign done     = live;
  assign comp_out = live & (sel_24m ? src_24 : src_48);
endmodule

// File: rtl/strap_clk_ctrl_chk.sv
module strap_clk_ctrl_chk #(
  parameter int WINDOW_CYCLES = 28636
) (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic src_48,
  input logic src_24,
  input logic pin_oe,
  input logic done,
  input logic sel_24m,
  input logic comp_out
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 2);
  localparam logic [CNT_W-1:0] WIN = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good)  run_cnt <= '0;
    else if (run_cnt <= WIN) run_cnt <= run_cnt + CNT_W'(1);
  end

  a_r2_not_early: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && pwr_good) |-> (run_cnt >= WIN));
  a_r2_on_time: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_oe) |-> (run_cnt == WIN));
  a_r2_not_late: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && run_cnt > WIN) |-> pin_oe);
  a_r3_done_tracks_oe: assert property (@(posedge clk) disable iff (rst)
    done == pin_oe);
  a_r5_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && pwr_good) |=> $stable(sel_24m));
  a_r6_comp_quiet: assert property (@(posedge clk) disable iff (rst)
    !done |-> !comp_out);
  a_r7_comp_48: assert property (@(posedge clk) disable iff (rst)
    (done && !sel_24m) |-> (comp_out == src_48));
  a_r7_comp_24: assert property (@(posedge clk) disable iff (rst)
    (done && sel_24m) |-> (comp_out == src_24));
  a_r8_drop_clears: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!pin_oe && !done && !sel_24m));
endmodule

bind strap_clk_ctrl strap_clk_ctrl_chk #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_good (pwr_good),
  .src_48   (src_48),
  .src_24   (src_24),
  .pin_oe   (pin_oe),
  .done     (done),
  .sel_24m  (sel_24m),
  .comp_out (comp_out)
);

// File: tb/sim_strap_clk_ctrl.sv
`timescale 1ns/1ps
module sim_strap_clk_ctrl;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0;
  logic pin_in = 1'b0;
  logic src_48 = 1'b1;
  logic src_24 = 1'b1;
  logic pin_oe, done, sel_24m, comp_out;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  strap_clk_ctrl #(.WINDOW_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .pin_in(pin_in),
    .src_48(src_48), .src_24(src_24), .pin_oe(pin_oe), .done(done),
    .sel_24m(sel_24m), .comp_out(comp_out)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 pin_oe", pin_oe, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 sel_24m", sel_24m, 1'b0);
    chk("R1 comp_out", comp_out, 1'b0);
    rst = 1'b0;
    tick(1);

    // Full window for each strap level
    for (int v = 0; v < 2; v++) begin
      pin_in = v[0];
      src_48 = 1'b1;
      src_24 = 1'b1;
      tick(3);
      pwr_good = 1'b1;
      tick(W - 1);
      chk("R2 oe before end", pin_oe, 1'b0);
      chk("R3 done before end", done, 1'b0);
      chk("R6 comp gated", comp_out, 1'b0);
      tick(1);
      chk("R2 oe at end", pin_oe, 1'b1);
      chk("R3 done at end", done, 1'b1);
      chk("R4 captured", sel_24m, v[0]);
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          src_48 = a[0];
          src_24 = b[0];
          #0.5;
          chk("R7 comp mux", comp_out, v[0] ? b[0] : a[0]);
        end
      end
      pin_in = ~v[0];
      tick(5);
      chk("R5 sel frozen", sel_24m, v[0]);
      chk("R5 oe held", pin_oe, 1'b1);
      pwr_good = 1'b0;
      tick(1);
      chk("R8 oe cleared", pin_oe, 1'b0);
      chk("R8 done cleared", done, 1'b0);
      chk("R8 sel cleared", sel_24m, 1'b0);
    end

    // R4: pad changes near the window end; only pin_in at edge W-2 counts
    for (int v = 0; v < 2; v++) begin
      for (int k = W - 4; k <= W - 1; k++) begin
        pin_in = v[0];
        tick(3);
        pwr_good = 1'b1;
        tick(k);
        pin_in = ~v[0];
        tick(W - k);
        chk("R4 late change", sel_24m, (k >= W - 2) ? v[0] : ~v[0]);
        pwr_good = 1'b0;
        tick(1);
      end
    end

    // R8: window cut short restarts from zero
    pin_in = 1'b1;
    tick(3);
    pwr_good = 1'b1;
    tick(10);
    pwr_good = 1'b0;
    tick(1);
    chk("R8 oe low after drop", pin_oe, 1'b0);
    pwr_good = 1'b1;
    tick(W - 1);
    chk("R8 restart no early oe", pin_oe, 1'b0);
    tick(1);
    chk("R8 restart oe", pin_oe, 1'b1);
    chk("R8 restart sel", sel_24m, 1'b1);

    // R1: reset while live
    rst = 1'b1;
    tick(1);
    chk("R1 live reset oe", pin_oe, 1'b0);
    chk("R1 live reset sel", sel_24m, 1'b0);
    chk("R1 live reset comp", comp_out, 1'b0);
    rst = 1'b0;
    tick(2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule